// File: doc/BRIEF.md
# Register-Window Spill/Fill Counter Unit

This block holds the bookkeeping state of a windowed register file with 64-bit registers. It keeps four window counters: free windows available for a save (`save_room`), windows that a restore can return to (`rest_room`), windows known to be clean (`clean_cnt`) and windows that belong to another address space (`other_cnt`). It also keeps a 6-bit spill/fill configuration (`spill_cfg`) and the current window pointer (`cur_win`). A command port carries save, restore, flush-windows, saved, restored and direct-write commands. For each command the unit either updates its state or reports a trap code for a spill, fill or clean-window trap. In either case the state is readable on its outputs at all times.

When a command traps, none of the state changes. The caller dispatches the trap and runs the handler outside this block. The handler later issues saved or restored commands. These move counts between `other_cnt` and the normal counters. A spill or fill code is built from a base code and a 3-bit handler selector taken from `spill_cfg`. The upper half of `spill_cfg` is used when `other_cnt` is nonzero, and the "other" flag is then set in the code. Otherwise the lower half is used.

A small state machine sequences each command. IDLE takes a command when `op_valid` is high and goes to EXEC. EXEC evaluates the command, updates the state and goes to RESP. RESP presents the one-cycle response and returns to IDLE.

Top module: `regwin_ctr_unit`

## Requirements
- R1: After reset the state is: `save_room`=NWIN-2, `rest_room`=0, `clean_cnt`=NWIN-1, `other_cnt`=0, `spill_cfg`=0, `cur_win`=0. At the same time `op_ready`=1 and `resp_valid`=0.
- R2: Save (op_code 0) with `save_room`≠0 and `clean_cnt`≠`rest_room` has these effects:
  - `save_room` decrements and `rest_room` increments.
  - `cur_win` steps down by one, wrapping from 0 to NWIN-1.
  - The response reports no trap, with `resp_tt`=0.
- R3: Save with `save_room`=0 reports a spill trap and changes no state.
- R4: Save with `save_room`≠0 and `clean_cnt`=`rest_room` reports a clean-window trap and changes no state. The trap code is CLEAN_BASE, which defaults to 0x024.
- R5: Restore (op_code 1) with `rest_room`≠0 has these effects:
  - `save_room` increments and `rest_room` decrements.
  - `cur_win` steps up by one, wrapping from NWIN-1 to 0.
  - The response reports no trap.
- R6: Restore with `rest_room`=0 reports a fill trap and changes no state.
- R7: A spill or fill code is its base (defaults 0x080 and 0x0C0) ORed with a sub-code:
  - When `other_cnt`≠0, the sub-code is OTHER_FLAG (default 0x020) OR (`spill_cfg`[5:3] << 2).
  - When `other_cnt`=0, the sub-code is `spill_cfg`[2:0] << 2.
- R8: Flush-windows (op_code 2) reports a spill trap unless `save_room`=NWIN-2. In either case it changes no state.
- R9: Saved (op_code 3) increments `save_room`. It then decrements `rest_room` if `other_cnt`=0, and decrements `other_cnt` otherwise.
- R10: Restored (op_code 4) increments `rest_room`. It increments `clean_cnt` only while `clean_cnt`<NWIN-1. It then decrements `save_room` if `other_cnt`=0, and decrements `other_cnt` otherwise.
- R11: Write (op_code 5) loads `wr_data` into the field selected by `wr_field`:
  - 0 selects `save_room`, 1 `rest_room`, 2 `clean_cnt`, 3 `other_cnt`, 4 `spill_cfg`, 5 `cur_win`.
  - A value written to `cur_win` is taken modulo NWIN.
  - `wr_field` 6/7 and op_code 6/7 change nothing and report no trap.
- R12: Timing of each command:
  - A command is taken on a clock edge where `op_valid` and `op_ready` are both high.
  - `resp_valid` is then high for exactly one cycle, starting at the next edge, and the new state is visible in that same cycle.
  - `op_ready` stays low from acceptance until the response has finished, and commands presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command present |
| op_code | input | 3 | Command code |
| wr_field | input | 3 | Field selector for the write command |
| wr_data | input | 6 | Data for the write command |
| op_ready | output | 1 | Unit idle, command will be taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_trap | output | 1 | Command trapped |
| resp_tt | output | TTW | Trap code, 0 when no trap |
| save_room | output | CW | Free-window counter |
| rest_room | output | CW | Restorable-window counter |
| clean_cnt | output | CW | Clean-window counter |
| other_cnt | output | CW | Other-space window counter |
| spill_cfg | output | 6 | Spill/fill handler selector |
| cur_win | output | CW | Current window pointer |

## Verification
The bench runs six saves from reset, which empties `save_room` and wraps `cur_win` downward. It then saves again with `spill_cfg` zero, then with a nonzero `spill_cfg`, and then with `other_cnt` nonzero. These three spill codes separate a wrong sub-field choice from a missing "other" flag. Saved and restored commands run with `other_cnt` both zero and nonzero, which shows which counter each one debits. Restored runs once with `clean_cnt` at its cap and once below it. Flush runs with `save_room` both at NWIN-2 and below it, and the clean-window trap is produced at two different counter values. Finally, a command held high through the busy cycles must yield a single update, and ignored write fields and op codes must leave every output unchanged.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

    typedef enum logic [2:0] {
        OP_SAVE     = 3'd0,
        OP_RESTORE  = 3'd1,
        OP_FLUSH    = 3'd2,
        OP_SAVED    = 3'd3,
        OP_RESTORED = 3'd4,
        OP_WRITE    = 3'd5,
        OP_NONE6    = 3'd6,
        OP_NONE7    = 3'd7
    } win_op_e;

    typedef enum logic [2:0] {
        FLD_SAVE_ROOM = 3'd0,
        FLD_REST_ROOM = 3'd1,
        FLD_CLEAN     = 3'd2,
        FLD_OTHER     = 3'd3,
        FLD_CFG       = 3'd4,
        FLD_CUR_WIN   = 3'd5,
        FLD_NONE6     = 3'd6,
        FLD_NONE7     = 3'd7
    } win_field_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SPILL = 2'd1,
        TK_FILL  = 2'd2,
        TK_CLEAN = 2'd3
    } trap_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/regwin_trap_enc.sv
`timescale 1ns/1ps
module regwin_trap_enc
    import regwin_pkg::*;
#(
    parameter int CW = 3,
    parameter int TTW = 9,
    parameter logic [TTW-1:0] SPILL_BASE = 9'h080,
    parameter logic [TTW-1:0] FILL_BASE  = 9'h0C0,
    parameter logic [TTW-1:0] CLEAN_BASE = 9'h024,
    parameter logic [TTW-1:0] OTHER_FLAG = 9'h020
) (
    input  trap_kind_e     kind,
    input  logic [CW-1:0]  other_cnt,
    input  logic [5:0]     cfg,
    output logic [TTW-1:0] tt
);

    logic [TTW-1:0] sub_code;

    // Handler selector: upper half of cfg when foreign windows remain.
    always_comb begin
        if (other_cnt != '0) begin
            sub_code = OTHER_FLAG | (TTW'(cfg[5:3]) << 2);
        end else begin
            sub_code = TTW'(cfg[2:0]) << 2;
        end
    end

    always_comb begin
        unique case (kind)
            TK_SPILL: tt = SPILL_BASE | sub_code;
            TK_FILL:  tt = FILL_BASE | sub_code;
            TK_CLEAN: tt = CLEAN_BASE;
            TK_NONE:  tt = '0;
        endcase
    end

endmodule

// File: rtl/regwin_ctr_next.sv
`timescale 1ns/1ps
module regwin_ctr_next
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW = $clog2(NWIN),
    parameter int DW = 6
) (
    input  win_op_e       op,
    input  win_field_e    field,
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] sr,
    input  logic [CW-1:0] rr,
    input  logic [CW-1:0] cl,
    input  logic [CW-1:0] ot,
    input  logic [5:0]    cfg,
    input  logic [CW-1:0] win,
    output logic [CW-1:0] sr_n,
    output logic [CW-1:0] rr_n,
    output logic [CW-1:0] cl_n,
    output logic [CW-1:0] ot_n,
    output logic [5:0]    cfg_n,
    output logic [CW-1:0] win_n,
    output trap_kind_e    kind
);

    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] LAST_WIN  = CW'(NWIN - 1);
    localparam logic [CW-1:0] FULL_SAVE = CW'(NWIN - 2);

    logic [CW-1:0] win_dn;
    logic [CW-1:0] win_up;
    logic [CW-1:0] win_wr;

    // Window pointer stepping: free wrap for a power-of-two count, explicit otherwise.
    generate
        if ((1 << CW) == NWIN) begin : g_pow2_wrap
            assign win_dn = win - ONE;
            assign win_up = win + ONE;
        end else begin : g_cmp_wrap
            assign win_dn = (win == '0) ? LAST_WIN : win - ONE;
            assign win_up = (win == LAST_WIN) ? '0 : win + ONE;
        end
    endgenerate

    assign win_wr = CW'(32'(data) % NWIN);

    always_comb begin
        sr_n  = sr;
        rr_n  = rr;
        cl_n  = cl;
        ot_n  = ot;
        cfg_n = cfg;
        win_n = win;
        kind  = TK_NONE;
        unique case (op)
            OP_SAVE: begin
                if (sr == '0) begin
                    kind = TK_SPILL;
                end else if (cl == rr) begin
                    kind = TK_CLEAN;
                end else begin
                    sr_n  = sr - ONE;
                    rr_n  = rr + ONE;
                    win_n = win_dn;
                end
            end
            OP_RESTORE: begin
                if (rr == '0) begin
                    kind = TK_FILL;
                end else begin
                    sr_n  = sr + ONE;
                    rr_n  = rr - ONE;
                    win_n = win_up;
                end
            end
            OP_FLUSH: begin
                if (sr != FULL_SAVE) begin
                    kind = TK_SPILL;
                end
            end
            OP_SAVED: begin
                sr_n = sr + ONE;
                if (ot == '0) begin
                    rr_n = rr - ONE;
                end else begin
                    ot_n = ot - ONE;
                end
            end
            OP_RESTORED: begin
                rr_n = rr + ONE;
                if (cl < LAST_WIN) begin
                    cl_n = cl + ONE;
                end
                if (ot == '0) begin
                    sr_n = sr - ONE;
                end else begin
                    ot_n = ot - ONE;
                end
            end
            OP_WRITE: begin
                unique case (field)
                    FLD_SAVE_ROOM: sr_n  = data[CW-1:0];
                    FLD_REST_ROOM: rr_n  = data[CW-1:0];
                    FLD_CLEAN:     cl_n  = data[CW-1:0];
                    FLD_OTHER:     ot_n  = data[CW-1:0];
                    FLD_CFG:       cfg_n = data[5:0];
                    FLD_CUR_WIN:   win_n = win_wr;
                    FLD_NONE6, FLD_NONE7: ;
                endcase
            end
            OP_NONE6, OP_NONE7: ;
        endcase
    end

endmodule

// File: rtl/regwin_ctr_unit.sv
`timescale 1ns/1ps
module regwin_ctr_unit
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int TTW = 9,
    parameter logic [TTW-1:0] SPILL_BASE = 9'h080,
    parameter logic [TTW-1:0] FILL_BASE  = 9'h0C0,
    parameter logic [TTW-1:0] CLEAN_BASE = 9'h024,
    parameter logic [TTW-1:0] OTHER_FLAG = 9'h020,
    localparam int CW = $clog2(NWIN),
    localparam int DW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [2:0]     op_code,
    input  logic [2:0]     wr_field,
    input  logic [DW-1:0]  wr_data,
    output logic           op_ready,
    output logic           resp_valid,
    output logic           resp_trap,
    output logic [TTW-1:0] resp_tt,
    output logic [CW-1:0]  save_room,
    output logic [CW-1:0]  rest_room,
    output logic [CW-1:0]  clean_cnt,
    output logic [CW-1:0]  other_cnt,
    output logic [5:0]     spill_cfg,
    output logic [CW-1:0]  cur_win
);

    seq_state_e    state_q, state_d;
    win_op_e       op_q;
    win_field_e    field_q;
    logic [DW-1:0] data_q;

    logic [CW-1:0] sr_n, rr_n, cl_n, ot_n, win_n;
    logic [5:0]    cfg_n;
    trap_kind_e    kind;
    logic [TTW-1:0] tt;

    logic accept;
    assign accept = (state_q == ST_IDLE) && op_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->EXEC on a command, EXEC->RESP, RESP->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        op_ready   = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: op_ready   = 1'b1;
            ST_EXEC: ;
            ST_RESP: resp_valid = 1'b1;
            default: ;
        endcase
    end

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE7;
            field_q <= FLD_NONE7;
            data_q  <= '0;
        end else if (accept) begin
            op_q    <= win_op_e'(op_code);
            field_q <= win_field_e'(wr_field);
            data_q  <= wr_data;
        end
    end

    regwin_ctr_next #(
        .NWIN (NWIN),
        .CW   (CW),
        .DW   (DW)
    ) u_next (
        .op    (op_q),
        .field (field_q),
        .data  (data_q),
        .sr    (save_room),
        .rr    (rest_room),
        .cl    (clean_cnt),
        .ot    (other_cnt),
        .cfg   (spill_cfg),
        .win   (cur_win),
        .sr_n  (sr_n),
        .rr_n  (rr_n),
        .cl_n  (cl_n),
        .ot_n  (ot_n),
        .cfg_n (cfg_n),
        .win_n (win_n),
        .kind  (kind)
    );

    regwin_trap_enc #(
        .CW         (CW),
        .TTW        (TTW),
        .SPILL_BASE (SPILL_BASE),
        .FILL_BASE  (FILL_BASE),
        .CLEAN_BASE (CLEAN_BASE),
        .OTHER_FLAG (OTHER_FLAG)
    ) u_enc (
        .kind      (kind),
        .other_cnt (other_cnt),
        .cfg       (spill_cfg),
        .tt        (tt)
    );

    // Window state and response registers, loaded in EXEC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_room <= CW'(NWIN - 2);
            rest_room <= '0;
            clean_cnt <= CW'(NWIN - 1);
            other_cnt <= '0;
            spill_cfg <= '0;
            cur_win   <= '0;
            resp_trap <= 1'b0;
            resp_tt   <= '0;
        end else if (state_q == ST_EXEC) begin
            save_room <= sr_n;
            rest_room <= rr_n;
            clean_cnt <= cl_n;
            other_cnt <= ot_n;
            spill_cfg <= cfg_n;
            cur_win   <= win_n;
            resp_trap <= (kind != TK_NONE);
            resp_tt   <= tt;
        end
    end

endmodule

// File: rtl/regwin_ctr_chk.sv
`timescale 1ns/1ps
module regwin_ctr_chk #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic          op_ready,
    input logic          resp_valid,
    input logic          resp_trap,
    input logic [CW-1:0] save_room,
    input logic [CW-1:0] rest_room,
    input logic [CW-1:0] clean_cnt,
    input logic [CW-1:0] other_cnt,
    input logic [CW-1:0] cur_win
);

    // R12
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R12
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> (!op_ready && !resp_valid));

    // R3
    spill_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == 3'd0 && save_room == '0)
            |=> ##1 (resp_valid && resp_trap));

    // R6
    fill_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == 3'd1 && rest_room == '0)
            |=> ##1 (resp_valid && resp_trap));

    // R4
    trap_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_trap) |->
            (save_room == $past(save_room) && rest_room == $past(rest_room) &&
             clean_cnt == $past(clean_cnt) && other_cnt == $past(other_cnt) &&
             cur_win == $past(cur_win)));

endmodule

bind regwin_ctr_unit regwin_ctr_chk #(.NWIN(NWIN)) u_regwin_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_ready   (op_ready),
    .resp_valid (resp_valid),
    .resp_trap  (resp_trap),
    .save_room  (save_room),
    .rest_room  (rest_room),
    .clean_cnt  (clean_cnt),
    .other_cnt  (other_cnt),
    .cur_win    (cur_win)
);

// File: tb/test_regwin_ctr_unit.sv
`timescale 1ns/1ps
module test_regwin_ctr_unit;

    localparam int NW = 8;
    localparam int M  = NW - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [2:0] wr_field = '0;
    logic [5:0] wr_data = '0;
    logic       op_ready, resp_valid, resp_trap;
    logic [8:0] resp_tt;
    logic [2:0] save_room, rest_room, clean_cnt, other_cnt, cur_win;
    logic [5:0] spill_cfg;

    always #2 clk = ~clk;

    regwin_ctr_unit #(.NWIN(NW)) i_regwin_ctr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_field(wr_field), .wr_data(wr_data), .op_ready(op_ready),
        .resp_valid(resp_valid), .resp_trap(resp_trap), .resp_tt(resp_tt),
        .save_room(save_room), .rest_room(rest_room), .clean_cnt(clean_cnt),
        .other_cnt(other_cnt), .spill_cfg(spill_cfg), .cur_win(cur_win)
    );

    typedef struct {
        int    trap;
        int    tt;
        int    sr, rr, cl, ot, ws, cw;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int m_sr, m_rr, m_cl, m_ot, m_ws, m_cw;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sub_code();
        if (m_ot != 0) return 'h20 | (((m_ws >> 3) & 7) << 2);
        return (m_ws & 7) << 2;
    endfunction

    // Driver: computes the expected result from the requirements, queues it, drives the command
    task automatic issue(int op, int fld, int data, string tag, int hold = 1);
        exp_t e;
        e.trap = 0;
        e.tt = 0;
        case (op)
            0: begin
                if (m_sr == 0) begin e.trap = 1; e.tt = 'h080 | sub_code(); end
                else if (m_cl == m_rr) begin e.trap = 1; e.tt = 'h024; end
                else begin m_sr--; m_rr++; m_cw = (m_cw == 0) ? M : m_cw - 1; end
            end
            1: begin
                if (m_rr == 0) begin e.trap = 1; e.tt = 'h0C0 | sub_code(); end
                else begin m_sr++; m_rr--; m_cw = (m_cw == M) ? 0 : m_cw + 1; end
            end
            2: if (m_sr != NW - 2) begin e.trap = 1; e.tt = 'h080 | sub_code(); end
            3: begin m_sr++; if (m_ot == 0) m_rr--; else m_ot--; end
            4: begin
                m_rr++;
                if (m_cl < M) m_cl++;
                if (m_ot == 0) m_sr--; else m_ot--;
            end
            5: case (fld)
                0: m_sr = data & 7;
                1: m_rr = data & 7;
                2: m_cl = data & 7;
                3: m_ot = data & 7;
                4: m_ws = data & 63;
                5: m_cw = data % NW;
                default: ;
            endcase
            default: ;
        endcase
        m_sr &= 7; m_rr &= 7; m_cl &= 7; m_ot &= 7;
        e.sr = m_sr; e.rr = m_rr; e.cl = m_cl; e.ot = m_ot; e.ws = m_ws; e.cw = m_cw;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_code  = 3'(op);
        wr_field = 3'(fld);
        wr_data  = 6'(data);
        op_valid = 1'b1;
        repeat (hold) @(negedge clk);
        op_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops one expected item per response and compares every output
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q.size() == 0) begin
                chk("R12", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "trap", int'(resp_trap), e.trap);
                chk(e.tag, "tt", int'(resp_tt), e.tt);
                chk(e.tag, "save_room", int'(save_room), e.sr);
                chk(e.tag, "rest_room", int'(rest_room), e.rr);
                chk(e.tag, "clean_cnt", int'(clean_cnt), e.cl);
                chk(e.tag, "other_cnt", int'(other_cnt), e.ot);
                chk(e.tag, "spill_cfg", int'(spill_cfg), e.ws);
                chk(e.tag, "cur_win", int'(cur_win), e.cw);
                chk(e.tag, "op_ready low in response", int'(op_ready), 0);
            end
        end
    end

    bit finished = 0;

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_sr = NW - 2; m_rr = 0; m_cl = M; m_ot = 0; m_ws = 0; m_cw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "save_room", int'(save_room), NW - 2);
        chk("R1", "rest_room", int'(rest_room), 0);
        chk("R1", "clean_cnt", int'(clean_cnt), M);
        chk("R1", "other_cnt", int'(other_cnt), 0);
        chk("R1", "spill_cfg", int'(spill_cfg), 0);
        chk("R1", "cur_win", int'(cur_win), 0);
        chk("R1", "op_ready", int'(op_ready), 1);
        chk("R1", "resp_valid", int'(resp_valid), 0);

        // R2 six saves, first one wraps cur_win 0 -> 7
        for (int i = 0; i < 6; i++) issue(0, 0, 0, "R2");
        // R3 spill with cfg zero
        issue(0, 0, 0, "R3");
        // R7 spill sub-field from low half, then from high half with other windows
        issue(5, 4, 'h2B, "R11");
        issue(0, 0, 0, "R7");
        issue(5, 3, 2, "R11");
        issue(0, 0, 0, "R7");
        // R9 saved with and without other windows
        issue(3, 0, 0, "R9");
        issue(3, 0, 0, "R9");
        issue(3, 0, 0, "R9");
        // R8 flush with room below NWIN-2
        issue(2, 0, 0, "R8");
        // R5 restores, then flush at NWIN-2
        for (int i = 0; i < 3; i++) issue(1, 0, 0, "R5");
        issue(2, 0, 0, "R8");
        // R6 fill with empty rest_room, both sub-fields
        issue(5, 0, 0, "R11");
        issue(5, 1, 0, "R11");
        issue(1, 0, 0, "R6");
        issue(5, 3, 1, "R11");
        issue(1, 0, 0, "R7");
        issue(5, 3, 0, "R11");
        // R4 clean-window trap at two counter values
        issue(5, 0, 2, "R11");
        issue(5, 2, 0, "R11");
        issue(0, 0, 0, "R4");
        issue(5, 1, 3, "R11");
        issue(5, 2, 3, "R11");
        issue(0, 0, 0, "R4");
        // R10 restored below cap, at cap, and with other windows
        issue(4, 0, 0, "R10");
        issue(5, 2, 7, "R11");
        issue(4, 0, 0, "R10");
        issue(5, 3, 2, "R11");
        issue(4, 0, 0, "R10");
        issue(5, 3, 0, "R11");
        // R11 cur_win written modulo NWIN, R5 restore wrap 7 -> 0
        issue(5, 5, 13, "R11");
        issue(5, 5, 7, "R11");
        issue(1, 0, 0, "R5");
        // R11 ignored field and ignored op codes
        issue(5, 6, 'h3F, "R11");
        issue(5, 7, 'h15, "R11");
        issue(6, 0, 0, "R11");
        issue(7, 0, 0, "R11");
        // R12 command held through busy cycles is taken once
        issue(0, 0, 0, "R12", 3);
        repeat (4) @(negedge clk);
        chk("R12", "queue drained", q.size(), 0);
        chk("R12", "idle ready", int'(op_ready), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule